// File: doc/BRIEF.md
# Saturating Narrowing Right-Shift Unit

This block takes one wide integer element from a 64-bit source, shifts it right by an immediate amount (optionally rounding first), and narrows it to half its width with saturation. Three sign treatments are available: signed in and signed out, unsigned in and unsigned out, and signed in with unsigned out. Each treatment comes in a truncating and a rounding form, which gives six legal operation encodings.

The operation is chosen by a U bit together with a 5-bit opcode. A 2-bit size code picks the narrow width of 8, 16 or 32 bits, and the source element is twice that width. When a valid strobe arrives with a legal encoding, the narrowed element is registered on the next clock. It is placed in the low bits of a zero-filled 64-bit result, along with a flag that says whether this operation clamped. A sticky flag collects every clamp until software-visible logic clears it. Illegal encodings are reported at once on a combinational output and change no state.

Top module: `sat_narrow_shr`

## Requirements
- R1: Legal operations and their {u_i, opcode_i} values are: {0,10010} signed-to-signed truncating, {1,10010} unsigned truncating, {0,10011} signed-to-signed rounding, {1,10011} unsigned rounding, {1,10000} signed-to-unsigned truncating, {1,10001} signed-to-unsigned rounding. Any other pair with valid_i high drives illegal_o high in the same cycle. illegal_o is low whenever valid_i is low.
- R2: size_i of 0, 1 or 2 selects a narrow width n of 8, 16 or 32 bits from a source element of 2n bits. size_i = 3 is illegal.
- R3: shift_i must satisfy 1 <= shift_i <= n. Any other value is illegal.
- R4: A strobe with an illegal encoding leaves res_o, sat_o and sat_sticky_o unchanged.
- R5: The signed-to-signed forms sign-extend the element, shift it arithmetically, and clamp to [-2^(n-1), 2^(n-1)-1]. sat_o is set when a clamp occurs.
- R6: The unsigned forms zero-extend the element and clamp to at most 2^n-1.
- R7: The signed-to-unsigned forms sign-extend the element, clamp negative results to 0, and clamp results above 2^n-1 to 2^n-1.
- R8: The rounding forms add 2^(shift-1) before shifting, using a sum wide enough that it never wraps.
- R9: Source bits at and above bit 2n have no effect on the result.
- R10: res_o holds the narrowed value in bits [n-1:0] and zero in every bit above.
- R11: res_o and sat_o update on the clock edge after a legal strobe, and hold while valid_i is low.
- R12: sat_sticky_o is set by any legal operation that clamps, and stays set until sat_clr_i. When a clamp and a clear arrive in the same cycle, the set wins.
- R13: While rst_ni is low, res_o, sat_o and sat_sticky_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| u_i | input | 1 | U bit of the operation encoding |
| opcode_i | input | 5 | Operation opcode |
| size_i | input | 2 | Narrow size code |
| shift_i | input | 6 | Right-shift amount |
| src_i | input | 64 | Source holding the wide element in its low bits |
| sat_clr_i | input | 1 | Clears the sticky saturation flag |
| res_o | output | 64 | Registered narrowed result, zero-filled above |
| sat_o | output | 1 | Registered clamp indication of the last accepted operation |
| sat_sticky_o | output | 1 | Cumulative saturation flag |
| illegal_o | output | 1 | Combinational illegal-encoding indication |

## Verification
The bench builds the unit with its default 64-bit source width, which instantiates all three lane widths. It also gives a 6-bit shift field, so shift values from 0 through 63 can be driven, covering both sides of every legal shift window. With the 64-bit lane present, the rounding path can be pushed against the largest positive and all-ones sources, where a sum of the source width alone would wrap. Random strobes mix legal and illegal encodings, set-and-clear collisions and idle cycles against a behavioural model that is checked on every operation.

// File: rtl/sns_pkg.sv
package sns_pkg;
  typedef enum logic [1:0] {
    KIND_SS = 2'd0,
    KIND_UU = 2'd1,
    KIND_SU = 2'd2
  } sns_kind_e;
endpackage

// File: rtl/sns_decode.sv
module sns_decode
  import sns_pkg::*;
#(
  parameter int unsigned SHW   = 6,
  parameter int unsigned NSIZE = 3
) (
  input  logic           u_i,
  input  logic [4:0]     opcode_i,
  input  logic [1:0]     size_i,
  input  logic [SHW-1:0] shift_i,
  output logic           legal_o,
  output sns_kind_e      kind_o,
  output logic           rnd_o
);
  logic op_ok, size_ok, shift_ok;

  always_comb begin
    op_ok = (opcode_i[4:1] == 4'b1001) || (u_i && opcode_i[4:1] == 4'b1000);
    size_ok = 32'(size_i) < NSIZE;
    shift_ok = (shift_i != '0) && (32'(shift_i) <= (32'd8 << size_i));
    legal_o = op_ok && size_ok && shift_ok;
    rnd_o = opcode_i[0];
    if (!opcode_i[1])  kind_o = KIND_SU;
    else if (u_i)      kind_o = KIND_UU;
    else               kind_o = KIND_SS;
  end
endmodule

// File: rtl/sns_lane.sv
module sns_lane
  import sns_pkg::*;
#(
  parameter int unsigned NW  = 8,
  parameter int unsigned SHW = 6
) (
  input  logic [2*NW-1:0] src_i,
  input  logic [SHW-1:0]  shift_i,
  input  sns_kind_e       kind_i,
  input  logic            rnd_i,
  output logic [NW-1:0]   val_o,
  output logic            sat_o
);
  localparam int unsigned WW = 2 * NW;
  localparam int unsigned EW = WW + 2;
  localparam logic signed [EW-1:0] SMAX = EW'((64'd1 << (NW - 1)) - 64'd1);
  localparam logic signed [EW-1:0] SMIN = -SMAX - EW'(1);
  localparam logic signed [EW-1:0] UMAX = EW'((64'd1 << NW) - 64'd1);

  logic signed [EW-1:0] ext, inc, sum, shd;
  logic                 sx;

  always_comb begin
    sx  = (kind_i != KIND_UU) && src_i[WW-1];
    ext = {{2{sx}}, src_i};
    inc = (rnd_i && shift_i != '0) ? (EW'(1) << (shift_i - SHW'(1))) : '0;
    sum = ext + inc;
    shd = sum >>> shift_i;
  end

  always_comb begin
    val_o = shd[NW-1:0];
    sat_o = 1'b0;
    if (kind_i == KIND_SS) begin
      if (shd > SMAX) begin
        val_o = SMAX[NW-1:0];
        sat_o = 1'b1;
      end else if (shd < SMIN) begin
        val_o = SMIN[NW-1:0];
        sat_o = 1'b1;
      end
    end else begin
      if (shd < 0) begin
        val_o = '0;
        sat_o = 1'b1;
      end else if (shd > UMAX) begin
        val_o = UMAX[NW-1:0];
        sat_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sat_narrow_shr.sv
module sat_narrow_shr
  import sns_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    u_i,
  input  logic [4:0]              opcode_i,
  input  logic [1:0]              size_i,
  input  logic [$clog2(XLEN)-1:0] shift_i,
  input  logic [XLEN-1:0]         src_i,
  input  logic                    sat_clr_i,
  output logic [XLEN-1:0]         res_o,
  output logic                    sat_o,
  output logic                    sat_sticky_o,
  output logic                    illegal_o
);
  localparam int unsigned SHW   = $clog2(XLEN);
  localparam int unsigned NSIZE = $clog2(XLEN / 8);
  localparam int unsigned HW    = XLEN / 2;

  logic      legal, rnd;
  sns_kind_e kind;

  sns_decode #(.SHW(SHW), .NSIZE(NSIZE)) u_dec (
    .u_i     (u_i),
    .opcode_i(opcode_i),
    .size_i  (size_i),
    .shift_i (shift_i),
    .legal_o (legal),
    .kind_o  (kind),
    .rnd_o   (rnd)
  );

  logic [HW-1:0] lane_val [NSIZE];
  logic          lane_sat [NSIZE];

  for (genvar g = 0; g < NSIZE; g++) begin : g_lane
    localparam int unsigned NW = 8 << g;
    logic [NW-1:0] val;
    sns_lane #(.NW(NW), .SHW(SHW)) u_lane (
      .src_i  (src_i[2*NW-1:0]),
      .shift_i(shift_i),
      .kind_i (kind),
      .rnd_i  (rnd),
      .val_o  (val),
      .sat_o  (lane_sat[g])
    );
    assign lane_val[g] = HW'(val);
  end

  logic [XLEN-1:0] res_nxt;
  logic            sat_nxt;
  logic            accept;

  always_comb begin
    res_nxt = '0;
    sat_nxt = 1'b0;
    for (int k = 0; k < NSIZE; k++) begin
      if (32'(size_i) == k) begin
        res_nxt = XLEN'(lane_val[k]);
        sat_nxt = lane_sat[k];
      end
    end
  end

  assign accept    = valid_i && legal;
  assign illegal_o = valid_i && !legal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o <= '0;
      sat_o <= 1'b0;
    end else if (accept) begin
      res_o <= res_nxt;
      sat_o <= sat_nxt;
    end
  end

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sat_sticky_o <= 1'b0;
    else if (accept && sat_nxt) sat_sticky_o <= 1'b1;
    else if (sat_clr_i)         sat_sticky_o <= 1'b0;
  end
endmodule

// File: rtl/sns_checker.sv
module sns_checker #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [1:0]      size_i,
  input logic            sat_clr_i,
  input logic [XLEN-1:0] res_o,
  input logic            sat_o,
  input logic            sat_sticky_o,
  input logic            illegal_o
);
  p_size3_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && size_i == 2'd3) |-> illegal_o);

  p_idle_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !illegal_o);

  p_illegal_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && illegal_o && !sat_clr_i) |=> ($stable(res_o) && $stable(sat_o) && $stable(sat_sticky_o)));

  p_zero_upper_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !illegal_o) |=> ((res_o >> (7'd8 << $past(size_i))) == '0));

  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(res_o) && $stable(sat_o)));

  p_sticky_keep_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_sticky_o && !sat_clr_i) |=> sat_sticky_o);

  p_sticky_follow_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !illegal_o) |=> (!sat_o || sat_sticky_o));
endmodule

bind sat_narrow_shr sns_checker #(.XLEN(XLEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .size_i      (size_i),
  .sat_clr_i   (sat_clr_i),
  .res_o       (res_o),
  .sat_o       (sat_o),
  .sat_sticky_o(sat_sticky_o),
  .illegal_o   (illegal_o)
);

// File: tb/tb_sat_narrow_shr.sv
module tb_sat_narrow_shr;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        u_i = 1'b0;
  logic [4:0]  opcode_i = '0;
  logic [1:0]  size_i = '0;
  logic [5:0]  shift_i = '0;
  logic [63:0] src_i = '0;
  logic        sat_clr_i = 1'b0;
  logic [63:0] res_o;
  logic        sat_o, sat_sticky_o, illegal_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [63:0] m_res = '0;
  bit          m_sat = 1'b0;
  bit          m_sticky = 1'b0;

  always #5 clk_i = ~clk_i;

  sat_narrow_shr dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .u_i(u_i),
    .opcode_i(opcode_i), .size_i(size_i), .shift_i(shift_i), .src_i(src_i),
    .sat_clr_i(sat_clr_i), .res_o(res_o), .sat_o(sat_o),
    .sat_sticky_o(sat_sticky_o), .illegal_o(illegal_o)
  );

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic void ref_op(input bit u, input bit [4:0] op, input int sz, input int sh,
                                 input logic [63:0] src, output bit ill,
                                 output logic [63:0] res, output bit sat);
    logic signed [127:0] x, lo, hi, one;
    bit legal_op, sgn;
    int n, w;
    legal_op = (op == 5'b10010) || (op == 5'b10011) || (u && (op == 5'b10000 || op == 5'b10001));
    ill = !legal_op || sz == 3 || sh < 1 || sh > (8 << sz);
    res = '0;
    sat = 1'b0;
    if (ill) return;
    n = 8 << sz;
    w = 2 * n;
    one = 128'sd1;
    sgn = !(u && op[1]);
    x = $signed({64'd0, src}) & ((one << w) - one);
    if (sgn && src[w-1]) x = x - (one << w);
    if (op[0]) x = x + (one << (sh - 1));
    x = x >>> sh;
    if (op[1] && !u) begin
      hi = (one << (n - 1)) - one;
      lo = -(one << (n - 1));
    end else begin
      hi = (one << n) - one;
      lo = 0;
    end
    if (x > hi) begin x = hi; sat = 1'b1; end
    else if (x < lo) begin x = lo; sat = 1'b1; end
    res = x[63:0] & ((64'd1 << n) - 64'd1);
  endfunction

  task automatic apply(bit v, bit u, bit [4:0] op, bit [1:0] sz, bit [5:0] sh,
                       logic [63:0] src, bit clr, string tag);
    bit e_ill, e_sat;
    logic [63:0] e_res;
    valid_i = v; u_i = u; opcode_i = op; size_i = sz; shift_i = sh;
    src_i = src; sat_clr_i = clr;
    #1;
    ref_op(u, op, int'(sz), int'(sh), src, e_ill, e_res, e_sat);
    chk(tag, "illegal_o", 64'(illegal_o), 64'(v && e_ill));
    if (v && !e_ill) begin m_res = e_res; m_sat = e_sat; end
    if (v && !e_ill && e_sat) m_sticky = 1'b1;
    else if (clr) m_sticky = 1'b0;
    @(posedge clk_i);
    #1;
    valid_i = 1'b0; sat_clr_i = 1'b0;
    @(negedge clk_i);
    chk(tag, "res_o", res_o, m_res);
    chk(tag, "sat_o", 64'(sat_o), 64'(m_sat));
    chk(tag, "sat_sticky_o", 64'(sat_sticky_o), 64'(m_sticky));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R13 reset state
    chk("R13", "res_o", res_o, '0);
    chk("R13", "sat_o", 64'(sat_o), 0);
    chk("R13", "sat_sticky_o", 64'(sat_sticky_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    apply(1, 0, 5'b10010, 0, 4, 64'h0000_0000_0000_0123, 0, "R5");
    apply(1, 0, 5'b10010, 0, 4, 64'h0000_0000_0000_1234, 0, "R5");
    apply(1, 0, 5'b10010, 0, 4, 64'h0000_0000_0000_F000, 1, "R5");
    apply(1, 0, 5'b10010, 1, 16, 64'h0000_0000_8000_0000, 1, "R5");
    apply(1, 0, 5'b10010, 2, 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, "R5");
    apply(1, 1, 5'b10010, 0, 1, 64'h0000_0000_0000_FFFF, 1, "R6");
    apply(1, 1, 5'b10010, 2, 32, 64'hFFFF_FFFF_FFFF_FFFF, 1, "R6");
    apply(1, 1, 5'b10000, 1, 8, 64'h0000_0000_FFFF_0000, 1, "R7");
    apply(1, 1, 5'b10000, 1, 8, 64'h0000_0000_00FF_FF00, 1, "R7");
    apply(1, 1, 5'b10000, 0, 8, 64'h0000_0000_0000_7F80, 1, "R7");
    apply(1, 0, 5'b10011, 2, 1, 64'h7FFF_FFFF_FFFF_FFFF, 1, "R8");
    apply(1, 1, 5'b10011, 2, 32, 64'hFFFF_FFFF_FFFF_FFFF, 1, "R8");
    apply(1, 0, 5'b10011, 0, 2, 64'h0000_0000_0000_0006, 1, "R8");
    apply(1, 1, 5'b10001, 0, 2, 64'h0000_0000_0000_FFFE, 1, "R8");
    apply(1, 0, 5'b10010, 0, 4, 64'hDEAD_BEEF_CAFE_0123, 1, "R9");
    apply(1, 1, 5'b10010, 1, 3, 64'hFFFF_FFFF_0000_1234, 0, "R9");
    apply(1, 0, 5'b10010, 2, 8, 64'h0123_4567_89AB_CDEF, 0, "R10");
    // illegal encodings leave state alone
    apply(1, 0, 5'b10010, 0, 4, 64'h0000_0000_0000_7FFF, 0, "R11");
    apply(1, 0, 5'b10000, 0, 4, 64'h0000_0000_0000_7FFF, 0, "R1");
    apply(1, 0, 5'b10001, 0, 4, 64'h0000_0000_0000_7FFF, 0, "R1");
    apply(1, 1, 5'b00010, 0, 4, 64'h0000_0000_0000_7FFF, 0, "R1");
    apply(1, 0, 5'b10010, 3, 4, 64'h0000_0000_0000_7FFF, 0, "R2");
    apply(1, 0, 5'b10010, 0, 0, 64'h0000_0000_0000_7FFF, 0, "R3");
    apply(1, 0, 5'b10010, 0, 9, 64'h0000_0000_0000_7FFF, 0, "R3");
    apply(1, 0, 5'b10010, 0, 8, 64'h0000_0000_0000_7FFF, 0, "R3");
    apply(1, 0, 5'b10010, 2, 33, 64'h0000_0000_0000_7FFF, 0, "R3");
    apply(1, 1, 5'b10010, 3, 4, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R4");
    apply(0, 1, 5'b10010, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R11");
    // sticky behaviour
    apply(0, 0, 5'b10010, 0, 4, 64'h0, 1, "R12");
    apply(1, 0, 5'b10010, 0, 4, 64'h0000_0000_0000_7FFF, 0, "R12");
    apply(0, 0, 5'b10010, 0, 4, 64'h0, 0, "R12");
    apply(1, 0, 5'b10010, 0, 4, 64'h0000_0000_0000_7FFF, 1, "R12");
    apply(1, 0, 5'b10010, 0, 4, 64'h0000_0000_0000_0010, 1, "R12");
    apply(1, 0, 5'b10010, 0, 4, 64'h0000_0000_0000_7FFF, 0, "R12");
    apply(1, 0, 5'b10000, 0, 4, 64'h0000_0000_0000_7FFF, 1, "R4");

    for (int i = 0; i < 400; i++) begin
      bit [4:0] op;
      int pick = $urandom_range(0, 7);
      case (pick)
        0: op = 5'b10000;
        1: op = 5'b10001;
        2, 3: op = 5'b10010;
        4, 5: op = 5'b10011;
        default: op = 5'($urandom);
      endcase
      apply(bit'($urandom_range(0, 4) != 0), bit'($urandom), op,
            2'($urandom_range(0, 3)), 6'($urandom_range(0, 34)),
            {$urandom, $urandom}, bit'($urandom_range(0, 5) == 0), "R5/R6/R7");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule